// File: doc/BRIEF.md
# Slave FIFO Burst Write Sequencer

This block is the master side of a synchronous slave FIFO port. It sends bursts of bytes into an external FIFO. A command gives a FIFO address, a byte count and a flag that asks for the data to be committed as a short packet. Payload bytes arrive on a valid/ready stream. The sequencer puts the address on the port with chip select, waits out the address setup, shows each byte one cycle before it strobes it, and keeps the strobe high for as long as bytes keep coming. When the flag is set it merges packet-end onto the edge of the last byte.

The full flag from the FIFO blocks the write strobe in the same cycle. The byte on the bus is held until the flag clears. After the last write and any packet-end, the block drops every strobe and raises `done` for one cycle. It then accepts the next command. All port strobes are active high, and every setup time is counted in whole clock cycles.

Top module: `sfw_wr_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `fifo_cs`, `fifo_wr`, `fifo_pktend` and `done` are low and `cmd_ready` is high.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the next cycle until `done` has been shown.
- R3: In the cycle after a command is taken, `fifo_cs` rises and `fifo_addr` carries the command address. The address stays stable while `fifo_cs` is high and through the packet-end cycle. The first `ADDR_GAP` cycles of chip select carry no write strobe.
- R4: A byte taken from the payload stream appears on `fifo_data` in the cycle after its handshake. `fifo_wr` rises no earlier than the cycle after that, with the data unchanged.
- R5: With payload always valid and the FIFO not full, the bytes of one command are written in consecutive cycles with `fifo_wr` held high throughout, so a count of N finishes N+3 cycles after the command handshake.
- R6: If the payload stream runs dry mid-burst, `fifo_wr` drops. On resumption the new byte is shown for one cycle without a strobe before it is written.
- R7: `fifo_wr` is never high in a cycle where `fifo_full` is high. The byte on the bus is then kept and is written once the flag clears.
- R8: With the commit bit set and a count above zero, `fifo_pktend` is high exactly once, in the same cycle as the write of the last byte. With the bit clear, it never rises.
- R9: A count of zero with the commit bit set gives exactly one `fifo_pktend` cycle and no write. A count of zero without it gives neither.
- R10: After the last write or packet-end, `done` is high for exactly one cycle with `fifo_cs`, `fifo_wr` and `fifo_pktend` low. `cmd_ready` is high in the following cycle.
- R11: Exactly the commanded number of bytes is written, in the order the payload stream delivered them, each with the command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_addr | input | AW | FIFO address for the command |
| cmd_count | input | CW | Number of bytes to write |
| cmd_commit | input | 1 | End the transfer with packet-end |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken on this edge |
| pl_data | input | DW | Payload byte |
| fifo_full | input | 1 | FIFO full flag, active high |
| fifo_addr | output | AW | FIFO address to the port |
| fifo_cs | output | 1 | Chip select, active high |
| fifo_data | output | DW | Data bus to the port |
| fifo_wr | output | 1 | Write strobe, active high |
| fifo_pktend | output | 1 | Packet-end strobe, active high |
| done | output | 1 | One-cycle pulse when a command has finished |

## Verification
Counting from the cycle whose closing edge takes the command (with the default one-cycle address gap), chip select is due one cycle later, the first byte on the bus two cycles later and the first strobe three cycles later. `done` follows N+3 cycles after the handshake for N bytes, three cycles for a packet-end-only command and two for an empty one. `fifo_wr` and `fifo_pktend` react to `fifo_full` in the same cycle. The bench therefore changes its inputs just after a rising edge and reads every output at the falling edge, which is when each of these results is settled. Directed commands with the stream always valid are timed against these fixed offsets. The random commands are judged cycle by cycle on order, address, the full flag, the data-before-strobe rule and the placement of packet-end.

// File: rtl/sfw_pkg.sv
// Package sfw_pkg
// Shared types for the slave FIFO write sequencer.
// Assumes nothing beyond the encodings below being private to the block.
package sfw_pkg;

    // Sequencer phases, in the order a command normally walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a command
        ST_ASET  = 3'd1,  // address and chip select out, no data yet
        ST_FETCH = 3'd2,  // payload ran dry, waiting for the next byte
        ST_DSET  = 3'd3,  // byte on the bus, strobe held off for setup
        ST_WRITE = 3'd4,  // strobe armed, one byte per unblocked edge
        ST_PEND  = 3'd5,  // packet-end without data
        ST_DONE  = 3'd6   // strobes released, completion pulse
    } sfw_state_e;

endpackage

// File: rtl/sfw_count.sv
// Module sfw_count
// Tracks the bytes still to be written for the current command and the
// address setup cycles spent so far.
// Assumes ADDR_GAP >= 1 and that dec is only raised while bytes remain.
module sfw_count #(
    parameter int CW       = 8,
    parameter int ADDR_GAP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic          gap_step,
    output logic          cnt_zero,
    output logic          cnt_last,
    output logic          gap_done
);

    localparam int GW = $clog2(ADDR_GAP) + 1;
    localparam logic [GW-1:0] GAP_END = GW'(ADDR_GAP - 1);

    logic [CW-1:0] remain_q;
    logic [GW-1:0] gap_q;

    // Bytes left: loaded at command take, counted down per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Address setup cycles: cleared per command, advanced while not yet met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (load) begin
            gap_q <= '0;
        end else if (gap_step && (gap_q != GAP_END)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign cnt_zero = (remain_q == '0);
    assign cnt_last = (remain_q == CW'(1));
    assign gap_done = (gap_q == GAP_END);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !cnt_zero); // R11

endmodule

// File: rtl/sfw_seq.sv
// Module sfw_seq
// Phase sequencer: takes commands, paces address setup, data setup and the
// burst, reacts to the full flag and an empty payload stream, and finishes
// with an optional packet-end and a completion pulse.
// Assumes the counter flags describe the command currently in flight.
module sfw_seq
    import sfw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic pl_valid,
    input  logic fifo_full,
    input  logic commit_q,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic gap_done,
    output logic cmd_ready,
    output logic pl_ready,
    output logic take_cmd,
    output logic load_byte,
    output logic byte_acc,
    output logic gap_step,
    output logic cs_on,
    output logic wr_arm,
    output logic pe_only,
    output logic done
);

    sfw_state_e state_q, state_d;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next phase and the handshakes that go with each phase.
    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        pl_ready  = 1'b0;
        take_cmd  = 1'b0;
        load_byte = 1'b0;
        byte_acc  = 1'b0;
        gap_step  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    take_cmd = 1'b1;
                    state_d  = ST_ASET;
                end
            end
            ST_ASET: begin
                if (!gap_done) begin
                    gap_step = 1'b1;
                end else if (cnt_zero) begin
                    state_d = commit_q ? ST_PEND : ST_DONE;
                end else begin
                    pl_ready = 1'b1;
                    if (pl_valid) begin
                        load_byte = 1'b1;
                        state_d   = ST_DSET;
                    end
                end
            end
            ST_FETCH: begin
                pl_ready = 1'b1;
                if (pl_valid) begin
                    load_byte = 1'b1;
                    state_d   = ST_DSET;
                end
            end
            ST_DSET: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (!fifo_full) begin
                    byte_acc = 1'b1;
                    if (cnt_last) begin
                        state_d = ST_DONE;
                    end else begin
                        pl_ready = 1'b1;
                        if (pl_valid) begin
                            load_byte = 1'b1;
                        end else begin
                            state_d = ST_FETCH;
                        end
                    end
                end
            end
            ST_PEND: begin
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign cs_on   = (state_q == ST_ASET) || (state_q == ST_FETCH) ||
                     (state_q == ST_DSET) || (state_q == ST_WRITE) ||
                     (state_q == ST_PEND);
    assign wr_arm  = (state_q == ST_WRITE);
    assign pe_only = (state_q == ST_PEND);
    assign done    = (state_q == ST_DONE);

    AST_TAKE_THEN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> cs_on); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs_on && !wr_arm && !pe_only)); // R10
    AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_on |-> !cmd_ready); // R2

endmodule

// File: rtl/sfw_bus.sv
// Module sfw_bus
// Port-side registers and strobe gating: holds the command address and commit
// flag, the byte on the data bus, and blocks the strobes while the FIFO is full.
// Assumes the sequencer raises load_byte only when a byte is handed over.
module sfw_bus #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_cmd,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_commit,
    input  logic          load_byte,
    input  logic [DW-1:0] pl_data,
    input  logic          fifo_full,
    input  logic          cs_on,
    input  logic          wr_arm,
    input  logic          pe_only,
    input  logic          cnt_last,
    output logic          commit_q,
    output logic [AW-1:0] fifo_addr,
    output logic          fifo_cs,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_wr,
    output logic          fifo_pktend
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Command address and commit flag: held until the next command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            commit_q <= 1'b0;
        end else if (take_cmd) begin
            addr_q   <= cmd_addr;
            commit_q <= cmd_commit;
        end
    end

    // Data bus register: changes only when a new byte is handed over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_byte) begin
            data_q <= pl_data;
        end
    end

    assign fifo_addr   = addr_q;
    assign fifo_cs     = cs_on;
    assign fifo_data   = data_q;
    assign fifo_wr     = wr_arm && !fifo_full;
    assign fifo_pktend = pe_only || (wr_arm && cnt_last && commit_q && !fifo_full);

    AST_NO_WR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr); // R7
    AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr || fifo_pktend) |-> fifo_cs); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cs && $past(fifo_cs)) |-> $stable(fifo_addr)); // R3
    AST_DATA_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr) |-> $stable(fifo_data)); // R4
    AST_FIRST_SELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_cs) |-> (!fifo_wr && !fifo_pktend)); // R3

endmodule

// File: rtl/sfw_wr_master.sv
// Module sfw_wr_master
// Top of the slave FIFO write sequencer. Joins the phase sequencer, the
// byte and setup counters and the port-side registers.
// Assumes a synchronous FIFO port on clk with active-high strobes, and setup
// times expressed as whole cycles (ADDR_GAP cycles of address before data).
module sfw_wr_master #(
    parameter int AW       = 2,
    parameter int DW       = 8,
    parameter int CW       = 8,
    parameter int ADDR_GAP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_commit,
    input  logic          pl_valid,
    output logic          pl_ready,
    input  logic [DW-1:0] pl_data,
    input  logic          fifo_full,
    output logic [AW-1:0] fifo_addr,
    output logic          fifo_cs,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_wr,
    output logic          fifo_pktend,
    output logic          done
);

    logic take_cmd, load_byte, byte_acc, gap_step;
    logic cnt_zero, cnt_last, gap_done;
    logic cs_on, wr_arm, pe_only, commit_q;

    sfw_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .pl_valid  (pl_valid),
        .fifo_full (fifo_full),
        .commit_q  (commit_q),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .gap_done  (gap_done),
        .cmd_ready (cmd_ready),
        .pl_ready  (pl_ready),
        .take_cmd  (take_cmd),
        .load_byte (load_byte),
        .byte_acc  (byte_acc),
        .gap_step  (gap_step),
        .cs_on     (cs_on),
        .wr_arm    (wr_arm),
        .pe_only   (pe_only),
        .done      (done)
    );

    sfw_count #(
        .CW       (CW),
        .ADDR_GAP (ADDR_GAP)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cmd),
        .load_val (cmd_count),
        .dec      (byte_acc),
        .gap_step (gap_step),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .gap_done (gap_done)
    );

    sfw_bus #(
        .AW (AW),
        .DW (DW)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_cmd    (take_cmd),
        .cmd_addr    (cmd_addr),
        .cmd_commit  (cmd_commit),
        .load_byte   (load_byte),
        .pl_data     (pl_data),
        .fifo_full   (fifo_full),
        .cs_on       (cs_on),
        .wr_arm      (wr_arm),
        .pe_only     (pe_only),
        .cnt_last    (cnt_last),
        .commit_q    (commit_q),
        .fifo_addr   (fifo_addr),
        .fifo_cs     (fifo_cs),
        .fifo_data   (fifo_data),
        .fifo_wr     (fifo_wr),
        .fifo_pktend (fifo_pktend)
    );

    AST_PKTEND_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pktend && fifo_wr) |-> cnt_last); // R8

endmodule

// File: tb/test_sfw_wr_master.sv
module test_sfw_wr_master;

    localparam int AW = 2;
    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          cmd_commit = 1'b0;
    logic          pl_valid = 1'b0;
    logic          pl_ready;
    logic [DW-1:0] pl_data = '0;
    logic          fifo_full = 1'b0;
    logic [AW-1:0] fifo_addr;
    logic          fifo_cs;
    logic [DW-1:0] fifo_data;
    logic          fifo_wr;
    logic          fifo_pktend;
    logic          done;

    int total = 0;
    int bad = 0;
    int tag = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sfw_wr_master #(.AW(AW), .DW(DW), .CW(CW), .ADDR_GAP(1)) i_sfw_wr_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .cmd_commit(cmd_commit),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .fifo_full(fifo_full), .fifo_addr(fifo_addr), .fifo_cs(fifo_cs),
        .fifo_data(fifo_data), .fifo_wr(fifo_wr), .fifo_pktend(fifo_pktend),
        .done(done)
    );

    // Payload byte i of command t.
    function automatic logic [7:0] pbyte(int t, int i);
        return 8'(t * 37 + i * 11 + 5);
    endfunction

    // Expected done offset from the command handshake cycle, stream always valid.
    function automatic int exp_done_ofs(int n, bit cm);
        if (n > 0) return n + 3;
        return cm ? 3 : 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_cmd(input logic [AW-1:0] a, input int n, input bit cm,
                           input int vpct, input int fpct, input bit timed);
        int idx, wcount, pe_cnt, pe_cyc, c0, first_cs, first_wr, last_wr, done_cyc;
        int err_data, err_full, err_pe, err_addr, err_busy, err_done, err_setup;
        int act_data, exp_data, data_at2;
        bit fired, pl_fire, prev_wr, prev_cs;
        logic [DW-1:0] prev_data;
        tag++;
        idx = 0; wcount = 0; pe_cnt = 0; pe_cyc = -1; c0 = -1; first_cs = -1;
        first_wr = -1; last_wr = -1; done_cyc = -1; data_at2 = -1;
        err_data = 0; err_full = 0; err_pe = 0; err_addr = 0; err_busy = 0;
        err_done = 0; err_setup = 0; act_data = 0; exp_data = 0;
        fired = 1'b0; prev_wr = 1'b0; prev_cs = 1'b0; prev_data = '0;
        @(posedge clk); #1;
        cmd_valid  = 1'b1;
        cmd_addr   = a;
        cmd_count  = CW'(n);
        cmd_commit = cm;
        pl_data    = pbyte(tag, 0);
        pl_valid   = (n > 0) && (($urandom % 100) < vpct);
        fifo_full  = (($urandom % 100) < fpct);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (!fired && cmd_valid && cmd_ready) begin
                fired = 1'b1;
                c0 = cyc;
            end else if (fired) begin
                if (fifo_cs && first_cs < 0) first_cs = cyc;
                if (fifo_cs && fifo_addr != a) err_addr++;
                if ((fifo_cs || fifo_wr) && cmd_ready) err_busy++;
                if (cyc == c0 + 2) data_at2 = (fifo_wr ? -2 : int'(fifo_data));
                if (fifo_wr) begin
                    if (fifo_full) err_full++;
                    if (fifo_data != pbyte(tag, wcount) && err_data == 0) begin
                        act_data = fifo_data;
                        exp_data = pbyte(tag, wcount);
                    end
                    if (fifo_data != pbyte(tag, wcount)) err_data++;
                    if (!prev_wr && (fifo_data != prev_data || !prev_cs)) err_setup++;
                    if (first_wr < 0) first_wr = cyc;
                    last_wr = cyc;
                end
                if (fifo_pktend) begin
                    pe_cnt++;
                    pe_cyc = cyc;
                    if (n > 0 && !(fifo_wr && wcount == n - 1)) err_pe++;
                    if (n == 0 && fifo_wr) err_pe++;
                end
                if (fifo_wr) wcount++;
                if (done) begin
                    done_cyc = cyc;
                    if (fifo_cs || fifo_wr || fifo_pktend) err_done++;
                end
            end
            prev_wr = fifo_wr;
            prev_cs = fifo_cs;
            prev_data = fifo_data;
            pl_fire = pl_valid && pl_ready;
            @(posedge clk); #1;
            if (fired) cmd_valid = 1'b0;
            if (pl_fire) idx++;
            pl_data   = pbyte(tag, idx);
            pl_valid  = fired && (idx < n) && (($urandom % 100) < vpct);
            fifo_full = (($urandom % 100) < fpct);
            if (done_cyc >= 0) break;
        end
        pl_valid = 1'b0;
        fifo_full = 1'b0;
        @(negedge clk);
        check(done_cyc >= 0, "R10 done seen", done_cyc, 1);
        check(cmd_ready && !done, "R10 ready after done", int'(cmd_ready), 1);
        check(wcount == n, "R11 byte count", wcount, n);
        check(err_data == 0, "R11 byte order", act_data, exp_data);
        check(err_addr == 0, "R3 address held", err_addr, 0);
        check(err_busy == 0, "R2 ready low while busy", err_busy, 0);
        check(err_full == 0, "R7 no write on full", err_full, 0);
        check(err_setup == 0, "R6 data shown before strobe", err_setup, 0);
        check(err_done == 0, "R10 quiet done", err_done, 0);
        check(err_pe == 0, "R8 pktend placement", err_pe, 0);
        if (n == 0) check(pe_cnt == (cm ? 1 : 0), "R9 empty command pktend", pe_cnt, cm ? 1 : 0);
        else        check(pe_cnt == (cm ? 1 : 0), "R8 pktend count", pe_cnt, cm ? 1 : 0);
        if (timed) begin
            check(first_cs == c0 + 1, "R3 select timing", first_cs - c0, 1);
            check(done_cyc == c0 + exp_done_ofs(n, cm), "R5 done timing",
                  done_cyc - c0, exp_done_ofs(n, cm));
            if (n > 0) begin
                check(data_at2 == int'(pbyte(tag, 0)), "R4 data one cycle early",
                      data_at2, int'(pbyte(tag, 0)));
                check(first_wr == c0 + 3, "R4 first strobe", first_wr - c0, 3);
                check(last_wr - first_wr == n - 1, "R5 strobe held over burst",
                      last_wr - first_wr, n - 1);
            end else if (cm) begin
                check(pe_cyc == c0 + 2, "R9 pktend timing", pe_cyc - c0, 2);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!fifo_cs && !fifo_wr && !fifo_pktend && !done && cmd_ready,
              "R1 outputs in reset", int'({fifo_cs, fifo_wr, fifo_pktend, done}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!fifo_cs && !fifo_wr && !fifo_pktend && !done && cmd_ready,
              "R1 outputs after reset", int'({fifo_cs, fifo_wr, fifo_pktend, done}), 0);

        // Directed corner cases.
        run_cmd(2'd1, 1, 1'b0, 100, 0, 1'b1);   // single byte
        run_cmd(2'd2, 4, 1'b1, 100, 0, 1'b1);   // burst with merged packet-end
        run_cmd(2'd3, 0, 1'b1, 100, 0, 1'b1);   // packet-end only
        run_cmd(2'd0, 0, 1'b0, 100, 0, 1'b1);   // empty command
        run_cmd(2'd1, 12, 1'b1, 100, 60, 1'b0); // heavy back-pressure
        run_cmd(2'd2, 10, 1'b0, 25, 0, 1'b0);   // sparse payload, stalls
        run_cmd(2'd3, 255, 1'b1, 100, 0, 1'b1); // longest count

        // Constrained random mix.
        for (int k = 0; k < 40; k++) begin
            run_cmd(AW'($urandom), int'($urandom % 21), 1'($urandom),
                    30 + int'($urandom % 71), int'($urandom % 41), 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule